// File: doc/BRIEF.md
# TPM Host Interrupt Event Generator

This block sits beside the status logic of a TPM host interface and turns changes in that logic into sticky interrupt status bits. It watches three status flags (command ready, status valid, data available) and the identity and validity of the currently active locality. It latches an event bit whenever one of the defined transitions occurs. The host reads the status byte and clears bits by writing ones to them. A single level interrupt request is formed from the latched bits, a per-source enable mask and a master enable. The master enable is supplied from configuration, because the legacy register window carries no global enable bit.

Edges are found by comparing each monitored input with a registered copy from the previous clock. Every copy clears to zero on reset. The data-available event is qualified in two ways: data becomes available while status is valid, or status becomes valid while data is already available. A locality-change event needs a locality to have been active at some point since reset. The very first activation therefore raises nothing.

Top module: `tis_irq_gen`

## Requirements
- R1: While reset is asserted and on release, `evt_stat_o` reads 0x00 and `irq_o` is 0.
- R2: A 0-to-1 change of `cmd_rdy_i` between two consecutive clock samples sets status bit 0 at the second of those edges.
- R3: A 0-to-1 change of `sts_vld_i` between two consecutive samples sets status bit 1.
- R4: Status bit 2 is set when `data_av_i` rises while `sts_vld_i` is 1, or when `sts_vld_i` rises while `data_av_i` is 1. A rise of `data_av_i` with `sts_vld_i` at 0 sets nothing.
- R5: Status bit 3 is set when a locality becomes active, provided some locality has been active since reset. A locality becomes active when `loc_vld_i` rises, or when `loc_act_i` changes while `loc_vld_i` stays 1. The first activation after reset, holding the same locality and releasing a locality set nothing.
- R6: A set status bit stays set until a cycle with `clr_we_i` at 1 and a 1 in the same position of `clr_mask_i`. A clear leaves every bit whose mask bit is 0 unchanged.
- R7: When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq_o` equals `master_en_i` AND the OR over bits 3..0 of (`evt_stat_o` AND `evt_en_i`). It follows the enables combinationally.
- R9: Bits 7..4 of `evt_stat_o` always read 0, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rdy_i | input | 1 | Command-ready status flag |
| sts_vld_i | input | 1 | Status-valid flag |
| data_av_i | input | 1 | Data-available flag |
| loc_act_i | input | LOC_W | Number of the active locality |
| loc_vld_i | input | 1 | A locality is currently active |
| evt_en_i | input | 4 | Per-source interrupt enables (bit order as status) |
| master_en_i | input | 1 | Master interrupt enable from configuration |
| clr_we_i | input | 1 | Write strobe for clearing status |
| clr_mask_i | input | STAT_W | Write-one-to-clear data |
| evt_stat_o | output | STAT_W | Interrupt status byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a three-bit locality number and an eight-bit status byte. With only three status flags, every ordered pair of flag states can be applied as a transition. All 64 pairs are checked, which covers both qualifying paths of the data-available event as well as its blocked case. Every subset of the four status bits is then combined with all sixteen enable masks and both master-enable values. Locality cases are run as a scripted walk through first activation, hold, seize, release and re-activation.

// File: rtl/tis_irq_gen.sv
module tis_irq_gen #(
  parameter int LOC_W  = 3,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rdy_i,
  input  logic              sts_vld_i,
  input  logic              data_av_i,
  input  logic [LOC_W-1:0]  loc_act_i,
  input  logic              loc_vld_i,
  input  logic [3:0]        evt_en_i,
  input  logic              master_en_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] evt_stat_o,
  output logic              irq_o
);
  localparam int NSRC = 4;
  localparam int PAD  = STAT_W - NSRC;

  logic             cr_q, sv_q, da_q, lv_q, seen_q;
  logic [LOC_W-1:0] loc_q;
  logic [NSRC-1:0]  stat_q, evt, clr;

  wire new_loc = loc_vld_i & (~lv_q | (loc_act_i != loc_q));

  assign evt[0] = cmd_rdy_i & ~cr_q;
  assign evt[1] = sts_vld_i & ~sv_q;
  assign evt[2] = (data_av_i & ~da_q & sts_vld_i) | (sts_vld_i & ~sv_q & data_av_i);
  assign evt[3] = new_loc & seen_q;
  assign clr    = clr_we_i ? clr_mask_i[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q   <= 1'b0;
      sv_q   <= 1'b0;
      da_q   <= 1'b0;
      lv_q   <= 1'b0;
      seen_q <= 1'b0;
      loc_q  <= '0;
      stat_q <= '0;
    end else begin
      cr_q   <= cmd_rdy_i;
      sv_q   <= sts_vld_i;
      da_q   <= data_av_i;
      lv_q   <= loc_vld_i;
      loc_q  <= loc_act_i;
      seen_q <= seen_q | loc_vld_i;
      stat_q <= (stat_q & ~clr) | evt;
    end
  end

  assign evt_stat_o = {{PAD{1'b0}}, stat_q};
  assign irq_o      = master_en_i & |(stat_q & evt_en_i);
endmodule

module tis_irq_gen_chk #(
  parameter int LOC_W  = 3,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_rdy_i,
  input logic              sts_vld_i,
  input logic              data_av_i,
  input logic [LOC_W-1:0]  loc_act_i,
  input logic              loc_vld_i,
  input logic [3:0]        evt_en_i,
  input logic              master_en_i,
  input logic              clr_we_i,
  input logic [STAT_W-1:0] clr_mask_i,
  input logic [STAT_W-1:0] evt_stat_o,
  input logic              irq_o
);
  logic             c_prev, s_prev, d_prev, v_prev, seen_c;
  logic [LOC_W-1:0] l_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_prev <= 1'b0;
      s_prev <= 1'b0;
      d_prev <= 1'b0;
      v_prev <= 1'b0;
      seen_c <= 1'b0;
      l_prev <= '0;
    end else begin
      c_prev <= cmd_rdy_i;
      s_prev <= sts_vld_i;
      d_prev <= data_av_i;
      v_prev <= loc_vld_i;
      seen_c <= seen_c | loc_vld_i;
      l_prev <= loc_act_i;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (evt_stat_o == '0 && !irq_o));
  // R2
  cmd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdy_i && !c_prev) |=> evt_stat_o[0]);
  // R3
  sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld_i && !s_prev) |=> evt_stat_o[1]);
  // R4
  data_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_av_i && !d_prev && sts_vld_i) |=> evt_stat_o[2]);
  // R5
  first_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_c && !evt_stat_o[3]) |=> !evt_stat_o[3]);
  // R5
  hold_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_vld_i && v_prev && loc_act_i == l_prev && !evt_stat_o[3]) |=> !evt_stat_o[3]);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stat_o[0] && !(clr_we_i && clr_mask_i[0])) |=> evt_stat_o[0]);
  // R2
  cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_stat_o[0]) |-> $past(cmd_rdy_i && !c_prev));
  // R8
  irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (master_en_i && |(evt_stat_o[3:0] & evt_en_i)));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stat_o[STAT_W-1:4] == '0);
endmodule

bind tis_irq_gen tis_irq_gen_chk #(.LOC_W(LOC_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rdy_i(cmd_rdy_i), .sts_vld_i(sts_vld_i),
  .data_av_i(data_av_i), .loc_act_i(loc_act_i), .loc_vld_i(loc_vld_i),
  .evt_en_i(evt_en_i), .master_en_i(master_en_i), .clr_we_i(clr_we_i),
  .clr_mask_i(clr_mask_i), .evt_stat_o(evt_stat_o), .irq_o(irq_o)
);

// File: tb/tis_irq_gen_test.sv
module tis_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rdy_i = 0, sts_vld_i = 0, data_av_i = 0, loc_vld_i = 0;
  logic [2:0] loc_act_i = '0;
  logic [3:0] evt_en_i = '0;
  logic       master_en_i = 0, clr_we_i = 0;
  logic [7:0] clr_mask_i = '0;
  logic [7:0] evt_stat_o;
  logic       irq_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  tis_irq_gen uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear(input logic [7:0] m);
    clr_we_i = 1; clr_mask_i = m;
    step();
    clr_we_i = 0; clr_mask_i = '0;
  endtask

  task automatic loc_step(input logic v, input logic [2:0] l, input logic exp, input string req);
    loc_vld_i = v; loc_act_i = l;
    step();
    chk(req, {31'd0, evt_stat_o[3]}, {31'd0, exp});
    clear(8'hFF);
  endtask

  task automatic set_all(input logic with_clr);
    cmd_rdy_i = 0; sts_vld_i = 0; data_av_i = 1; loc_vld_i = 1; loc_act_i = 0;
    step(); step();
    clear(8'hFF);
    cmd_rdy_i = 1; sts_vld_i = 1; loc_act_i = 1;
    if (with_clr) begin clr_we_i = 1; clr_mask_i = 8'hFF; end
    step();
    clr_we_i = 0; clr_mask_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", evt_stat_o, 0);
    chk("R1 reset irq", irq_o, 0);
    rst_n = 1;
    step();
    chk("R1 after release", {irq_o, evt_stat_o}, 0);

    // R2 R3 R4: all flag transitions
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) begin
        logic [2:0] pv, nv;
        logic cr, sr, dr;
        pv = p[2:0]; nv = n[2:0];
        {cmd_rdy_i, sts_vld_i, data_av_i} = pv;
        step();
        clear(8'hFF);
        {cmd_rdy_i, sts_vld_i, data_av_i} = nv;
        step();
        cr = ~pv[2] & nv[2];
        sr = ~pv[1] & nv[1];
        dr = (~pv[0] & nv[0] & nv[1]) | (~pv[1] & nv[1] & nv[0]);
        chk("R2 R3 R4 transition", evt_stat_o, {29'd0, dr, sr, cr});
      end
    end

    // R6 sticky and selective clear
    {cmd_rdy_i, sts_vld_i, data_av_i} = 3'b000;
    step(); clear(8'hFF);
    {cmd_rdy_i, sts_vld_i, data_av_i} = 3'b111;
    step(); step(); step();
    chk("R6 held", evt_stat_o, 8'h07);
    clear(8'h02);
    chk("R6 selective clear", evt_stat_o, 8'h05);
    clear(8'h05);
    chk("R6 full clear", evt_stat_o, 8'h00);
    {cmd_rdy_i, sts_vld_i, data_av_i} = 3'b000;
    step();

    // R5 locality sequence
    loc_step(1, 3'd2, 0, "R5 first activation");
    loc_step(1, 3'd2, 0, "R5 hold");
    loc_step(1, 3'd4, 1, "R5 seize");
    loc_step(0, 3'd4, 0, "R5 release");
    loc_step(1, 3'd1, 1, "R5 after release");
    loc_step(0, 3'd1, 0, "R5 release again");
    loc_step(1, 3'd1, 1, "R5 reactivate same");

    // R7 set beats clear
    set_all(1);
    chk("R7 set wins", evt_stat_o, 8'h0F);
    // R9 upper bits
    clear(8'hF0);
    chk("R9 upper clear no effect", evt_stat_o, 8'h0F);

    // R8 irq sweep
    for (int pat = 0; pat < 16; pat++) begin
      logic [3:0] pp;
      pp = pat[3:0];
      set_all(0);
      clear({4'h0, ~pp});
      chk("R6 R9 pattern", evt_stat_o, {28'd0, pp});
      for (int en = 0; en < 16; en++) begin
        for (int m = 0; m < 2; m++) begin
          logic [3:0] ev;
          logic mv;
          ev = en[3:0]; mv = m[0];
          evt_en_i = ev; master_en_i = mv;
          #1;
          chk("R8 irq", irq_o, {31'd0, mv & |(pp & ev)});
        end
      end
      evt_en_i = '0; master_en_i = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule